// File: doc/BRIEF.md
# Serial Gamepad Shift Reader

This block reads a simple eight-button gamepad that holds its buttons in a parallel-load, serial-out shift register. Three wires connect the two. The block drives a latch strobe and a shift clock, and it receives one returning data line. A single-cycle trigger starts one read. The block raises the latch, samples the first button while the latch is still high, and then gives exactly eight clock pulses. It samples one further button after each of the first seven pulses. The pad drives its data low for a pressed button, so every sample is inverted as it is stored. When the eighth pulse ends, the finished byte appears with a one-cycle strobe. A downstream queue or handler can take that strobe as the push of one word.

All timing counts ticks of a step enable input. With the enable at 1 MHz, the latch lasts 12 µs and each clock phase lasts 6 µs. The latch and clock leave the block as one 2-bit side output. Clock is on bit 0 and latch is on bit 1. Between reads both bits rest low.

Top module: `gamepad_shift_reader`

## Requirements
- R1: After a synchronous reset, and at any time while no read is in progress, `side_out` is 2'b00 and `btn_valid` is 0. A reset during a read abandons the read, and no byte is delivered for it.
- R2: A `trigger` seen at a clock edge while idle starts a read. From the next cycle, the latch bit (`side_out[1]`) is high.
- R3: The latch stays high for exactly LATCH_STEPS (12) step ticks. Exactly NUM_BITS (8) clock pulses follow. Each pulse is HALF_STEPS (6) ticks high (`side_out[0]`=1) and then HALF_STEPS ticks low.
- R4: The side output carries the clock on bit 0 and the latch on bit 1. The two are never high together.
- R5: `side_out` changes only on an edge where `step_en` was high, or on the edge that accepts a trigger.
- R6: Bit 0 is sampled at the last latch tick. Bit k (k = 1..7) is sampled at the last tick of the low phase of clock pulse k. Each sample is stored inverted into `btn_byte[k]`, so a low data line gives a 1. The order is bit 0 = A, 1 = B, 2 = Select, 3 = Start, 4 = Up, 5 = Down, 6 = Left, 7 = Right.
- R7: The cycle after the last tick of the eighth pulse's low phase, `btn_valid` is high for exactly one cycle, `btn_byte` holds the new byte and `side_out` is already 2'b00. `btn_byte` then holds its value until the next delivery.
- R8: A trigger that arrives while a read is in progress is ignored. A trigger in the cycle where `btn_valid` is high is accepted and starts a new read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step tick that sets the sequencing rate |
| trigger | input | 1 | Single-cycle read request |
| pad_data_n | input | 1 | Serial data from the pad, active low |
| side_out | output | 2 | Bit 0 shift clock, bit 1 latch |
| btn_byte | output | NUM_BITS | Last captured button byte, 1 = pressed |
| btn_valid | output | 1 | One-cycle strobe for a new byte |

## Verification
The hardest situations to reach from the ports are triggers that land at awkward points: in the middle of a read, and in the exact cycle where the previous byte is being delivered. The stimulus fires extra triggers at several offsets inside a read. It also fires a trigger in the negative half of the `btn_valid` cycle, so that the next edge sees the block idle. A behavioural pad model shifts real patterns out on the block's own edges. Three step-enable spacings are used, including one tick every cycle, to vary phase alignment. A reset is also forced in the middle of a read.

// File: rtl/gpad_pkg.sv
package gpad_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LATCH  = 2'd1,
        PH_CLK_HI = 2'd2,
        PH_CLK_LO = 2'd3
    } phase_e;

    // packed so that clk sits in bit 0 and latch in bit 1
    typedef struct packed {
        logic latch;
        logic clk;
    } side_t;

    function automatic side_t side_for(phase_e ph);
        side_t s;
        s.latch = (ph == PH_LATCH);
        s.clk   = (ph == PH_CLK_HI);
        return s;
    endfunction

endpackage

// File: rtl/gpad_step_timer.sv
module gpad_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          step_en,
    input  logic [CW-1:0] term,
    output logic          last_tick
);
    logic [CW-1:0] cnt;

    assign last_tick = step_en && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (step_en) begin
            cnt <= last_tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/gpad_sequencer.sv
module gpad_sequencer
    import gpad_pkg::*;
#(
    parameter int NUM_BITS    = 8,
    parameter int LATCH_STEPS = 12,
    parameter int HALF_STEPS  = 6,
    parameter int CW          = 4,
    parameter int IW          = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trigger,
    input  logic          last_tick,
    output logic          busy,
    output logic [CW-1:0] term,
    output side_t         side,
    output logic          sample_en,
    output logic [IW-1:0] sample_idx,
    output logic          done
);
    localparam logic [CW-1:0] LATCH_TERM = CW'(LATCH_STEPS - 1);
    localparam logic [CW-1:0] HALF_TERM  = CW'(HALF_STEPS - 1);
    localparam logic [IW-1:0] LAST_PULSE = IW'(NUM_BITS - 1);

    phase_e        phase;
    logic [IW-1:0] pidx;
    logic          lo_end;

    assign busy       = (phase != PH_IDLE);
    assign term       = (phase == PH_LATCH) ? LATCH_TERM : HALF_TERM;
    assign side       = side_for(phase);
    assign lo_end     = (phase == PH_CLK_LO) && last_tick;
    assign done       = lo_end && (pidx == LAST_PULSE);
    assign sample_en  = ((phase == PH_LATCH) && last_tick) || (lo_end && (pidx != LAST_PULSE));
    assign sample_idx = (phase == PH_LATCH) ? '0 : pidx + IW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            pidx  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (trigger) begin
                        phase <= PH_LATCH;
                        pidx  <= '0;
                    end
                end
                PH_LATCH:  if (last_tick) phase <= PH_CLK_HI;
                PH_CLK_HI: if (last_tick) phase <= PH_CLK_LO;
                PH_CLK_LO: begin
                    if (last_tick) begin
                        if (pidx == LAST_PULSE) begin
                            phase <= PH_IDLE;
                        end else begin
                            pidx  <= pidx + IW'(1);
                            phase <= PH_CLK_HI;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    latch_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(side.latch) |-> $past(trigger));
endmodule

// File: rtl/gpad_capture.sv
module gpad_capture #(
    parameter int NUM_BITS = 8,
    parameter int IW       = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic [IW-1:0]       sample_idx,
    input  logic                data_n,
    input  logic                done,
    output logic [NUM_BITS-1:0] byte_out,
    output logic                valid
);
    localparam int KW = $clog2(NUM_BITS + 1);

    logic [NUM_BITS-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow   <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= done;
            if (sample_en) shadow[sample_idx] <= ~data_n;
            if (done) byte_out <= shadow;
        end
    end

    logic [KW-1:0] chk_samples;
    always_ff @(posedge clk) begin
        if (rst || done) chk_samples <= '0;
        else if (sample_en) chk_samples <= chk_samples + KW'(1);
    end

    // R7
    one_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6
    sample_total_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_samples == KW'(NUM_BITS)));
endmodule

// File: rtl/gamepad_shift_reader.sv
module gamepad_shift_reader
    import gpad_pkg::*;
#(
    parameter int NUM_BITS    = 8,
    parameter int LATCH_STEPS = 12,
    parameter int HALF_STEPS  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                trigger,
    input  logic                pad_data_n,
    output logic [1:0]          side_out,
    output logic [NUM_BITS-1:0] btn_byte,
    output logic                btn_valid
);
    localparam int MAX_STEPS = (LATCH_STEPS > HALF_STEPS) ? LATCH_STEPS : HALF_STEPS;
    localparam int CW        = $clog2(MAX_STEPS + 1);
    localparam int IW        = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;

    logic          busy;
    logic          last_tick;
    logic [CW-1:0] term;
    side_t         side;
    logic          sample_en;
    logic [IW-1:0] sample_idx;
    logic          done;

    gpad_step_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (!busy),
        .step_en   (step_en),
        .term      (term),
        .last_tick (last_tick)
    );

    gpad_sequencer #(
        .NUM_BITS    (NUM_BITS),
        .LATCH_STEPS (LATCH_STEPS),
        .HALF_STEPS  (HALF_STEPS),
        .CW          (CW),
        .IW          (IW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .trigger    (trigger),
        .last_tick  (last_tick),
        .busy       (busy),
        .term       (term),
        .side       (side),
        .sample_en  (sample_en),
        .sample_idx (sample_idx),
        .done       (done)
    );

    gpad_capture #(.NUM_BITS(NUM_BITS), .IW(IW)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .sample_idx (sample_idx),
        .data_n     (pad_data_n),
        .done       (done),
        .byte_out   (btn_byte),
        .valid      (btn_valid)
    );

    assign side_out = side;

    // R5
    step_rate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(side_out) |-> ($past(step_en) || $past(trigger)));

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        btn_valid |-> (side_out == 2'b00));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(side_out[0]) |-> !side_out[1] && $past(!side_out[0]));
endmodule

// File: tb/test_gamepad_shift_reader.sv
module test_gamepad_shift_reader;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int LS = 12;
    localparam int HS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic trigger = 1'b0;
    logic pad_data_n;
    logic [1:0] side_out;
    logic [NB-1:0] btn_byte;
    logic btn_valid;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamepad_shift_reader i_gamepad_shift_reader (
        .clk(clk), .rst(rst), .step_en(step_en), .trigger(trigger),
        .pad_data_n(pad_data_n), .side_out(side_out),
        .btn_byte(btn_byte), .btn_valid(btn_valid)
    );

    // pad model: latch reloads position, each rising clock shifts
    logic [NB-1:0] pad_buttons = '0;
    int pad_pos = 0;
    always @(posedge side_out[1]) pad_pos = 0;
    always @(posedge side_out[0]) pad_pos = pad_pos + 1;
    assign pad_data_n = (pad_pos < NB) ? ~pad_buttons[pad_pos[2:0]] : 1'b0;

    // step tick generator
    int step_div = 4;
    int div_cnt = 0;
    always @(negedge clk) begin
        if (div_cnt >= step_div - 1) begin
            div_cnt = 0;
            step_en <= 1'b1;
        end else begin
            div_cnt = div_cnt + 1;
            step_en <= 1'b0;
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 latch, 2 clock high, 3 clock low
    int m_phase = 0, m_ticks = 0, m_pulse = 0;
    bit [NB-1:0] m_bits = '0;
    bit [NB-1:0] e_byte = '0;
    bit e_valid = 0;
    bit [1:0] e_side = 2'b00;
    int lat_ticks = 0, hi_ticks = 0, clk_rises = 0, latch_rises = 0, valid_count = 0;

    always @(posedge clk) begin
        if (side_out[1] && step_en) lat_ticks++;
        if (side_out[0] && step_en) hi_ticks++;
        e_valid = 0;
        if (rst) begin
            m_phase = 0; m_ticks = 0; m_pulse = 0; m_bits = '0; e_byte = '0;
        end else if (m_phase == 0) begin
            if (trigger) begin m_phase = 1; m_ticks = 0; m_pulse = 0; end
        end else if (step_en) begin
            if (m_phase == 1) begin
                if (m_ticks == LS - 1) begin
                    m_bits[0] = ~pad_data_n; m_phase = 2; m_ticks = 0;
                end else m_ticks++;
            end else if (m_phase == 2) begin
                if (m_ticks == HS - 1) begin m_phase = 3; m_ticks = 0; end
                else m_ticks++;
            end else begin
                if (m_ticks == HS - 1) begin
                    m_ticks = 0;
                    if (m_pulse == NB - 1) begin
                        e_valid = 1; e_byte = m_bits; m_phase = 0;
                    end else begin
                        m_pulse++; m_bits[m_pulse] = ~pad_data_n; m_phase = 2;
                    end
                end else m_ticks++;
            end
        end
        e_side = {m_phase == 1, m_phase == 2};
    end

    logic [1:0] prev_side = 2'b00;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R5 side_out vs model", int'(side_out), int'(e_side));
            check("R7 btn_valid vs model", int'(btn_valid), int'(e_valid));
            if (e_valid) check("R6 btn_byte vs model", int'(btn_byte), int'(e_byte));
            if (side_out == 2'b11) check("R4 clock and latch together", 1, 0);
            if (side_out[0] && !prev_side[0]) clk_rises++;
            if (side_out[1] && !prev_side[1]) latch_rises++;
            if (btn_valid) valid_count++;
        end
        prev_side = side_out;
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic wait_valid(string req);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (btn_valid) return;
        end
        check({req, " timeout waiting for btn_valid"}, 0, 1);
    endtask

    task automatic clear_meas();
        lat_ticks = 0; hi_ticks = 0; clk_rises = 0; latch_rises = 0;
    endtask

    task automatic read_pattern(logic [NB-1:0] pat);
        pad_buttons = pat;
        clear_meas();
        fire();
        check("R2 latch high after trigger", int'(side_out[1]), 1);
        wait_valid("R7");
        check("R6 byte equals pressed pattern", int'(btn_byte), int'(pat));
        check("R3 latch length in ticks", lat_ticks, LS);
        check("R3 clock pulse count", clk_rises, NB);
        check("R3 clock high ticks", hi_ticks, NB * HS);
        check("R7 side idle at valid", int'(side_out), 0);
        @(negedge clk);
        check("R7 valid lasts one cycle", int'(btn_valid), 0);
        check("R7 byte held", int'(btn_byte), int'(pat));
        cycles(20);
        check("R1 idle between reads", int'({side_out, btn_valid}), 0);
    endtask

    task automatic summary();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cycles(4);
        check("R1 reset side_out", int'(side_out), 0);
        check("R1 reset btn_valid", int'(btn_valid), 0);
        rst = 1'b0;
        cycles(10);
        check("R1 idle without trigger", int'({side_out, btn_valid}), 0);

        read_pattern(8'h00);
        read_pattern(8'hFF);
        read_pattern(8'hA5);
        read_pattern(8'h01);
        read_pattern(8'h80);

        step_div = 1;
        read_pattern(8'h5A);
        step_div = 7;
        read_pattern(8'h3C);
        step_div = 4;

        // R8: triggers during a read are ignored
        begin
            int v0;
            pad_buttons = 8'hC3;
            clear_meas();
            v0 = valid_count;
            fire();
            cycles(37);  fire();
            cycles(150); fire();
            cycles(90);  fire();
            wait_valid("R8");
            check("R8 busy trigger ignored, byte intact", int'(btn_byte), 8'hC3);
            cycles(800);
            check("R8 one delivery for busy triggers", valid_count - v0, 1);
            check("R8 one latch pulse", latch_rises, 1);
        end

        // R8: trigger in the valid cycle is accepted
        pad_buttons = 8'h96;
        fire();
        wait_valid("R8");
        pad_buttons = 8'h69;
        trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
        check("R8 trigger in valid cycle starts read", int'(side_out[1]), 1);
        wait_valid("R8");
        check("R8 back-to-back byte", int'(btn_byte), 8'h69);
        cycles(20);

        // R1: reset in the middle of a read
        begin
            int v0;
            pad_buttons = 8'h0F;
            fire();
            cycles(200);
            rst = 1'b1;
            cycles(2);
            check("R1 reset mid-read side_out", int'(side_out), 0);
            check("R1 reset mid-read btn_valid", int'(btn_valid), 0);
            check("R1 reset clears byte", int'(btn_byte), 0);
            rst = 1'b0;
            v0 = valid_count;
            cycles(1500);
            check("R1 no delivery after abandoned read", valid_count - v0, 0);
            read_pattern(8'hE7);
        end

        summary();
    end
endmodule